// File: doc/BRIEF.md
# SPI memory identification probe

This block sequences the identification read of a ferroelectric memory on an SPI bus. It sits on the master side and controls a separate byte shifter through a request and acknowledge pair. It asks that shifter to move one byte at a time and keeps the device select asserted for the whole frame. It runs once on its own when reset is released, and again each time it receives a start pulse while it is idle.

Each frame begins with the identify opcode. Next comes a manufacturer field of up to six bytes, which ends early when the first byte is the one-byte vendor code. Then come a memory-type byte, a capacity byte and a variant byte. The block ignores the manufacturer and memory-type bytes. It looks up the capacity and variant pair in a parameter table and reports the result with a one-cycle found or not-found pulse. The pulse comes with the memory size in bytes and the number of address bytes the part expects.

Top module: `spi_id_probe`

## Requirements
- R1: With reset asserted, select, request, busy, found and not_found are all low. One probe starts on the first clock after reset is released, with no start pulse. A start pulse while idle begins another probe.
- R2: Each probe raises spi_sel together with a request carrying opcode 0x9F. Every later request in the same frame carries the filler byte 0xA5.
- R3: The manufacturer field can be up to six bytes long. If its first returned byte is 0x04, it ends after that one byte, so the frame has 5 transfers. A 0x04 in any later position does not shorten it, so the frame has 10 transfers.
- R4: Exactly three transfers follow the manufacturer field: memory type, capacity, then variant. spi_sel is low from the cycle in which found or not_found pulses.
- R5: A match needs both the capacity byte and the variant byte to equal a table entry. The manufacturer bytes and the memory-type byte have no effect on the result.
- R6: When no entry matches, not_found pulses and mem_bytes and addr_len read 0.
- R7: The default table reports these results, as capacity/variant → bytes and address length:
  - 0x21/0x00 → 16384 bytes, 2
  - 0x22/0x08 → 32768 bytes, 2
  - 0x24/0x00 → 131072 bytes, 3
  - 0x26/0x08 → 524288 bytes, 3

  Every entry with capacity 0x21 to 0x23 has a 2-byte address.
- R8: busy is high from the cycle after a probe starts through the cycle of its result pulse. A start pulse while busy is ignored.
- R9: found and not_found are single-cycle pulses and never occur together. mem_bytes and addr_len hold their values until the next probe ends.
- R10: xfer_go lasts one cycle. The next request is raised only after xfer_ack has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new probe (one cycle) |
| xfer_go | output | 1 | Ask the shifter to exchange one byte |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Shifter finished the exchange |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_ack |
| spi_sel | output | 1 | Device select, active high |
| busy | output | 1 | Probe in progress |
| found | output | 1 | Pulse: device recognised |
| not_found | output | 1 | Pulse: no table entry matched |
| mem_bytes | output | SIZE_W | Capacity of the recognised part in bytes |
| addr_len | output | 2 | Address bytes of the recognised part |

## Verification
A wrong phase or a wrong manufacturer count shows up at the next request as an opcode or filler byte the model did not expect. If the frame is cut short, it shows at the result pulse as a missing or extra transfer. A stuck pending flag stops the stream of requests, and the missing result pulse then exposes it. A wrong capture of the capacity or variant byte appears in the same cycle as the result pulse, as a wrong size or address length. The bench model tracks the expected request stream on every clock and compares busy against select, so a fault is reported within one transfer of its first effect.

// File: rtl/spi_idp_pkg.sv
package spi_idp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_MFR, ST_MEM, ST_CAP, ST_VAR
   } idp_state_e;

   localparam logic [7:0] CMD_IDENT       = 8'h9F;
   localparam logic [7:0] PAD_BYTE        = 8'hA5;
   localparam logic [7:0] ONE_BYTE_VENDOR = 8'h04;
endpackage

// File: rtl/idp_kick.sv
module idp_kick (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ready,
   output logic launch
);
   logic boot_q;

   assign launch = ready && (start || boot_q);

   always_ff @(posedge clk) begin
      if (!rst_n)      boot_q <= 1'b1;
      else if (launch) boot_q <= 1'b0;
   end
endmodule

// File: rtl/idp_seq.sv
module idp_seq
   import spi_idp_pkg::*;
#(
   parameter int MFR_MAX = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       xfer_ack,
   input  logic [7:0] xfer_rx,
   output logic       xfer_go,
   output logic [7:0] xfer_tx,
   output logic       spi_sel,
   output logic       idle,
   output logic       fin,
   output logic [7:0] cap_q
);
   localparam int CW = $clog2(MFR_MAX);

   generate
      if (MFR_MAX < 2) begin : g_bad_mfr
         $error("idp_seq: MFR_MAX must be at least 2");
      end
   endgenerate

   idp_state_e    state;
   logic          pend;
   logic [CW-1:0] cnt;
   logic          mfr_last;

   assign idle     = (state == ST_IDLE);
   assign spi_sel  = !idle;
   assign xfer_go  = !idle && !pend;
   assign xfer_tx  = (state == ST_OPC) ? CMD_IDENT : PAD_BYTE;
   assign fin      = (state == ST_VAR) && xfer_ack;
   assign mfr_last = ((cnt == '0) && (xfer_rx == ONE_BYTE_VENDOR)) ||
                     (cnt == CW'(MFR_MAX - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pend  <= 1'b0;
         cnt   <= '0;
         cap_q <= '0;
      end else begin
         if (xfer_ack)     pend <= 1'b0;
         else if (xfer_go) pend <= 1'b1;
         case (state)
            ST_IDLE: if (launch) state <= ST_OPC;
            ST_OPC: if (xfer_ack) begin
               state <= ST_MFR;
               cnt   <= '0;
            end
            ST_MFR: if (xfer_ack) begin
               if (mfr_last) state <= ST_MEM;
               else          cnt   <= cnt + CW'(1);
            end
            ST_MEM: if (xfer_ack) state <= ST_CAP;
            ST_CAP: if (xfer_ack) begin
               cap_q <= xfer_rx;
               state <= ST_VAR;
            end
            ST_VAR: if (xfer_ack) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_OPC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sel) |-> (xfer_go && xfer_tx == CMD_IDENT)); // R2
   AST_SHORT_VENDOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MFR && xfer_ack && cnt == '0 && xfer_rx == ONE_BYTE_VENDOR)
      |=> state == ST_MEM); // R3
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && !xfer_ack) |=> !xfer_go); // R10
   AST_STAY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !fin) |=> !idle); // R8
endmodule

// File: rtl/idp_lookup.sv
module idp_lookup #(
   parameter int                     NUM_ENT  = 8,
   parameter int                     SIZE_W   = 24,
   parameter logic [NUM_ENT*8-1:0]   TBL_CAP  = '0,
   parameter logic [NUM_ENT*8-1:0]   TBL_VAR  = '0,
   parameter logic [NUM_ENT*5-1:0]   TBL_LOG2 = '0,
   parameter logic [NUM_ENT*2-1:0]   TBL_ALEN = '0
) (
   input  logic [7:0]        cap,
   input  logic [7:0]        var_b,
   output logic              hit,
   output logic [SIZE_W-1:0] size_bytes,
   output logic [1:0]        alen
);
   generate
      if (NUM_ENT < 1) begin : g_bad_ent
         $error("idp_lookup: NUM_ENT must be at least 1");
      end
      if (SIZE_W < 1 || SIZE_W > 32) begin : g_bad_size
         $error("idp_lookup: SIZE_W must be 1..32");
      end
   endgenerate

   logic [NUM_ENT-1:0] hits;

   genvar g;
   generate
      for (g = 0; g < NUM_ENT; g++) begin : g_ent
         assign hits[g] = (cap == TBL_CAP[g*8 +: 8]) && (var_b == TBL_VAR[g*8 +: 8]);
      end
   endgenerate

   always_comb begin
      hit        = |hits;
      size_bytes = '0;
      alen       = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (hits[i]) begin
            size_bytes = SIZE_W'(1) << TBL_LOG2[i*5 +: 5];
            alen       = TBL_ALEN[i*2 +: 2];
         end
      end
   end
endmodule

// File: rtl/spi_id_probe.sv
module spi_id_probe #(
   parameter int                   NUM_ENT  = 8,
   parameter int                   SIZE_W   = 24,
   parameter int                   MFR_MAX  = 6,
   parameter logic [NUM_ENT*8-1:0] TBL_CAP  =
      {8'h26, 8'h25, 8'h24, 8'h23, 8'h22, 8'h22, 8'h21, 8'h21},
   parameter logic [NUM_ENT*8-1:0] TBL_VAR  =
      {8'h08, 8'h08, 8'h00, 8'h00, 8'h08, 8'h00, 8'h08, 8'h00},
   parameter logic [NUM_ENT*5-1:0] TBL_LOG2 =
      {5'd19, 5'd18, 5'd17, 5'd16, 5'd15, 5'd15, 5'd14, 5'd14},
   parameter logic [NUM_ENT*2-1:0] TBL_ALEN =
      {2'd3, 2'd3, 2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              xfer_go,
   output logic [7:0]        xfer_tx,
   input  logic              xfer_ack,
   input  logic [7:0]        xfer_rx,
   output logic              spi_sel,
   output logic              busy,
   output logic              found,
   output logic              not_found,
   output logic [SIZE_W-1:0] mem_bytes,
   output logic [1:0]        addr_len
);
   logic              launch, idle, fin, hit;
   logic [7:0]        cap_q;
   logic [SIZE_W-1:0] size_w;
   logic [1:0]        alen_w;

   assign busy = !idle || found || not_found;

   idp_kick u_kick (
      .clk(clk), .rst_n(rst_n), .start(start), .ready(!busy), .launch(launch)
   );

   idp_seq #(.MFR_MAX(MFR_MAX)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .xfer_go(xfer_go), .xfer_tx(xfer_tx), .spi_sel(spi_sel),
      .idle(idle), .fin(fin), .cap_q(cap_q)
   );

   idp_lookup #(
      .NUM_ENT(NUM_ENT), .SIZE_W(SIZE_W), .TBL_CAP(TBL_CAP),
      .TBL_VAR(TBL_VAR), .TBL_LOG2(TBL_LOG2), .TBL_ALEN(TBL_ALEN)
   ) u_lookup (
      .cap(cap_q), .var_b(xfer_rx), .hit(hit), .size_bytes(size_w), .alen(alen_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         found     <= 1'b0;
         not_found <= 1'b0;
         mem_bytes <= '0;
         addr_len  <= '0;
      end else begin
         found     <= fin && hit;
         not_found <= fin && !hit;
         if (fin) begin
            mem_bytes <= size_w;
            addr_len  <= alen_w;
         end
      end
   end

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && not_found)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (found || not_found) |=> !(found || not_found)); // R9
   AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (found || not_found) |-> !spi_sel); // R4
   AST_NF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      not_found |-> (mem_bytes == '0 && addr_len == 2'd0)); // R6
   AST_GO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |-> spi_sel); // R2
endmodule

// File: tb/tb_spi_id_probe.sv
module tb_spi_id_probe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        xfer_ack = 1'b0;
   logic [7:0]  xfer_rx = 8'h00;
   logic        xfer_go, spi_sel, busy, found, not_found;
   logic [7:0]  xfer_tx;
   logic [23:0] mem_bytes;
   logic [1:0]  addr_len;

   always #10 clk = ~clk;

   spi_id_probe dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .spi_sel(spi_sel), .busy(busy), .found(found), .not_found(not_found),
      .mem_bytes(mem_bytes), .addr_len(addr_len)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // reference model state
   logic [7:0] rsp[$];
   logic [7:0] exp_tx[$];
   int dly_cfg  = 1;
   int wait_cnt = -1;
   int go_seen  = 0;
   int done_cnt = 0;
   bit got_found;
   int got_size, got_alen;

   initial begin
      forever begin
         @(negedge clk);
         xfer_ack = 1'b0;
         if (rst_n) begin
            if (xfer_go) begin
               go_seen++;
               if (exp_tx.size() == 0)
                  check(1'b0, "R3", "unexpected transfer", xfer_tx, 0);
               else begin
                  logic [7:0] e;
                  e = exp_tx.pop_front();
                  check(xfer_tx == e, "R2", "shifted byte", xfer_tx, e);
               end
               check(spi_sel, "R2", "select with request", spi_sel, 1);
               wait_cnt = dly_cfg;
            end
            if (wait_cnt == 0) begin
               xfer_ack = 1'b1;
               xfer_rx  = (rsp.size() != 0) ? rsp.pop_front() : 8'h00;
               wait_cnt = -1;
            end else if (wait_cnt > 0) begin
               wait_cnt--;
            end
            if (found || not_found) begin
               done_cnt++;
               got_found = found;
               got_size  = int'(mem_bytes);
               got_alen  = int'(addr_len);
               check(!spi_sel, "R4", "select at result", spi_sel, 0);
               check(busy, "R8", "busy at result", busy, 1);
               check(!(found && not_found), "R9", "exclusive result", found, 0);
            end else begin
               check(busy == spi_sel, "R8", "busy tracks frame", busy, spi_sel);
            end
         end
      end
   end

   // mfr: up to six bytes, first byte in [47:40]; n: how many the slave returns
   task automatic probe(input logic [47:0] mfr, input int n, input logic [7:0] mem,
                        input logic [7:0] cap, input logic [7:0] vr,
                        input bit use_start, input bit mid_start,
                        input bit exp_found, input int exp_size, input int exp_alen,
                        input string req);
      int go0, d0, waited;
      rsp.delete();
      exp_tx.delete();
      rsp.push_back(8'h00);
      exp_tx.push_back(8'h9F);
      for (int k = 0; k < n; k++) rsp.push_back(mfr[47-8*k -: 8]);
      rsp.push_back(mem);
      rsp.push_back(cap);
      rsp.push_back(vr);
      for (int k = 0; k < n + 3; k++) exp_tx.push_back(8'hA5);
      go0 = go_seen;
      d0  = done_cnt;
      @(negedge clk);
      if (use_start) start = 1'b1;
      else           rst_n = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (mid_start) begin
         waited = 0;
         while (go_seen < go0 + 3 && waited < 500) begin
            @(negedge clk);
            waited++;
         end
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      waited = 0;
      while (done_cnt == d0 && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      check(done_cnt == d0 + 1, req, "result pulse count", done_cnt - d0, 1);
      check(got_found == exp_found, req, "found", got_found, exp_found);
      check(got_size == exp_size, "R7", "size", got_size, exp_size);
      check(got_alen == exp_alen, "R7", "addr len", got_alen, exp_alen);
      check(go_seen - go0 == n + 4, "R3", "transfer count", go_seen - go0, n + 4);
      check(exp_tx.size() == 0, "R4", "transfers left", exp_tx.size(), 0);
      repeat (6) @(negedge clk);
      check(go_seen - go0 == n + 4, "R8", "no extra probe", go_seen - go0, n + 4);
      check(done_cnt == d0 + 1, "R9", "single result", done_cnt - d0, 1);
      check(int'(mem_bytes) == exp_size, "R9", "size held", mem_bytes, exp_size);
      check(int'(addr_len) == exp_alen, "R9", "addr len held", addr_len, exp_alen);
      check(!busy && !spi_sel, "R8", "idle after probe", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!spi_sel && !xfer_go && !busy, "R1", "reset outputs", {spi_sel, xfer_go, busy}, 0);
      check(!found && !not_found, "R1", "reset result", {found, not_found}, 0);
      // R1: boot probe, full six manufacturer bytes (R3), 3-byte part (R7)
      dly_cfg = 1;
      probe(48'h7F7F7F7F7F7F, 6, 8'hC2, 8'h24, 8'h00, 1'b0, 1'b0, 1'b1, 131072, 3, "R1");
      // R3: short vendor code ends manufacturer field after one byte
      dly_cfg = 0;
      probe(48'h040000000000, 1, 8'h2E, 8'h22, 8'h08, 1'b1, 1'b0, 1'b1, 32768, 2, "R3");
      // R3: 0x04 in second position does not shorten
      dly_cfg = 3;
      probe(48'h7F047F7F7FC2, 6, 8'hC2, 8'h26, 8'h08, 1'b1, 1'b0, 1'b1, 524288, 3, "R3");
      // R5/R6: capacity matches, variant does not
      dly_cfg = 2;
      probe(48'h7F7F7F7F7F7F, 6, 8'hC2, 8'h24, 8'h01, 1'b1, 1'b0, 1'b0, 0, 0, "R6");
      // R5: other manufacturer and memory bytes, same pair as before
      dly_cfg = 1;
      probe(48'h1122334455AA, 6, 8'h00, 8'h22, 8'h08, 1'b1, 1'b0, 1'b1, 32768, 2, "R5");
      // R8: start while busy ignored; R7: smallest part
      dly_cfg = 2;
      probe(48'h7F7F7F7F7F7F, 6, 8'hC2, 8'h21, 8'h00, 1'b1, 1'b1, 1'b1, 16384, 2, "R8");
      // R6: unknown pair after a short vendor code
      dly_cfg = 0;
      probe(48'h040000000000, 1, 8'h2A, 8'h05, 8'h09, 1'b1, 1'b0, 1'b0, 0, 0, "R6");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      check(1'b0, "R10", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule